// File: doc/BRIEF.md
# DDR2 Mode Register Programming Sequencer

This block sits on the memory-controller side and writes the two configuration registers of a DDR2 SDRAM: the base mode register and the first extended mode register. The caller sets the configuration fields and raises a one-bit request with a register select. The block packs the fields into a 14-bit address word and drives one mode-register-set command on the command pins. The fields are burst length, burst type, CAS latency, DLL reset, power-down exit speed, DLL disable, output drive strength, termination value, additive latency, driver calibration, strobe complement disable and read strobe enable. The write-recovery field is not given directly. The block computes it from the write-recovery time and the clock period, both in picoseconds, rounding the cycle count up.

Requests use a valid/ready handshake. `req_ready` is high only when three things hold: the caller reports all banks precharged (`banks_idle`), the clock-enable state is high (`cke_on`), and the spacing window of the previous command has closed. A request that is not accepted must be held with its fields stable until `req_ready` rises. The handshake completes on a rising edge where both signals are high. A request whose base-register fields hold a reserved code is still accepted, but it produces an error pulse instead of a command. The registers can be rewritten at any time during normal operation under the same rules.

When no command is issued, the pins carry a no-operation code. `configured` reports that both registers have been written since reset and that no spacing window is open.

Top module: `ddr2_mrs_seq`

## Requirements
- R1: Outside a command cycle, and once the first clock edge after reset has passed, the pins carry a no-operation code: chip select low; row strobe, column strobe and write enable high; bank bits 00 and address 0. During reset, chip select is high.
- R2: A handshake with valid fields puts a mode-register-set command on the pins in the following cycle, for exactly one cycle. The command has chip select, row strobe, column strobe and write enable all low. The bank bits are 00 when `req_sel`=0 (base register) and 01 when `req_sel`=1 (extended register 1).
- R3: `req_ready` is high only when `banks_idle` and `cke_on` are both high and no spacing window is open. No command is issued while either precondition is low.
- R4: Two consecutive commands are at least MRS_GAP cycles apart. With the request held valid, the next command comes exactly MRS_GAP cycles after the previous one.
- R5: The base register word has these fields. A2:A0 is the burst-length code (010 = 4, 011 = 8). A3 is the burst type. A6:A4 is the CAS latency, equal to its cycle count. A7 is 0. A8 is DLL reset. A11:A9 is the write-recovery code. A12 is power-down exit (1 = slow). A13 is 0.
- R6: The extended register 1 word has these fields. A0 is DLL disable. A1 is reduced drive. A2 is termination bit 0 and A6 is termination bit 1. A5:A3 is the additive latency. A9:A7 is driver calibration. A10 is strobe complement disable. A11 is read strobe enable. A12 and A13 are 0.
- R7: The write-recovery cycle count is the smallest integer n with n·tCK ≥ tWR. The block encodes it in A11:A9 as n−1.
- R8: A base-register request is rejected when any of these holds: the burst-length code is not 010 or 011, the CAS latency is outside 3..6, or the write-recovery count is outside 2..6. A rejected request still completes its handshake. It raises `err` for one cycle in the cycle after the handshake, issues no command and opens no window. Extended-register requests are never rejected for base-register fields.
- R9: `done` pulses for one cycle in the last cycle of each command's spacing window. That cycle is MRS_GAP−1 cycles after the command cycle, which makes it the command cycle itself when MRS_GAP=1.
- R10: `configured` is low after reset. It is high only once at least one base-register command and one extended-register command have been issued since reset and no spacing window is open.
- R11: During reset, `done`, `err` and `configured` are low and no command is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks are precharged |
| cke_on | input | 1 | Clock enable is already high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 1 | 0 = base register, 1 = extended register 1 |
| cfg_bl | input | 3 | Burst-length code |
| cfg_bt | input | 1 | Burst type (1 = interleave) |
| cfg_cl | input | 3 | CAS latency in cycles |
| cfg_dll_rst | input | 1 | DLL reset |
| cfg_pd_slow | input | 1 | Slow power-down exit |
| cfg_twr_ps | input | PS_W | Write-recovery time in ps |
| cfg_tck_ps | input | PS_W | Clock period in ps |
| cfg_dll_off | input | 1 | DLL disable |
| cfg_drv_half | input | 1 | Reduced output drive |
| cfg_odt | input | 2 | Termination value select |
| cfg_al | input | 3 | Additive latency |
| cfg_drv_cal | input | 3 | Driver calibration control |
| cfg_strobe_cmp_off | input | 1 | Disable complementary data strobe |
| cfg_rdstrobe_on | input | 1 | Enable read data strobe |
| cmd_csel_n | output | 1 | Chip select, active low |
| cmd_rowstb_n | output | 1 | Row strobe, active low |
| cmd_colstb_n | output | 1 | Column strobe, active low |
| cmd_wen_n | output | 1 | Write enable, active low |
| cmd_bank | output | 2 | Bank address (register select) |
| cmd_addr | output | 14 | Address bus |
| done | output | 1 | Spacing window of last command expired |
| err | output | 1 | Request rejected for reserved code |
| configured | output | 1 | Both registers written, bus free |

## Verification
The bench holds a request valid while the preconditions are low. A block that ignored `banks_idle` or `cke_on` would issue a command that the model does not predict. It sends back-to-back requests to pin the spacing at exactly MRS_GAP: an off-by-one counter shows up either as a gap one cycle too long or as a command inside the window. It drives write-recovery times on both sides of an exact multiple of the clock period. A truncating divider would produce a code one too low. It sends reserved burst-length, latency and recovery values, and an extended-register request carrying such values. A block that checked the wrong register would either issue a bad command or refuse a good one. It also checks that `configured` stays low until both registers have been written at least once.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;

  localparam int ADDR_W = 14;

  localparam logic [2:0] BL_CODE_4 = 3'b010;
  localparam logic [2:0] BL_CODE_8 = 3'b011;
  localparam int CL_MIN = 3;
  localparam int CL_MAX = 6;
  localparam int WR_MIN = 2;
  localparam int WR_MAX_OK = 6;

  typedef enum logic {
    SEL_MR   = 1'b0,
    SEL_EMR1 = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       dll_rst;
    logic       pd_slow;
  } mr_fields_t;

  typedef struct packed {
    logic       dll_off;
    logic       drv_half;
    logic [1:0] odt;
    logic [2:0] al;
    logic [2:0] drv_cal;
    logic       strobe_cmp_off;
    logic       rdstrobe_on;
  } emr_fields_t;

endpackage

// File: rtl/mrs_wr_calc.sv
module mrs_wr_calc #(
  parameter int PS_W   = 16,
  parameter int WR_MAX = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] twr_ps,
  input  logic [PS_W-1:0] tck_ps,
  output logic [2:0]      wr_code,
  output logic            wr_ok
);
  import ddr2_mrs_pkg::*;

  localparam int CW = $clog2(WR_MAX + 1);
  localparam int PW = PS_W + CW;

  logic [WR_MAX:1] hit;
  logic [CW-1:0]   cyc;

  // hit[n]: n clock periods cover the recovery time
  for (genvar n = 1; n <= WR_MAX; n++) begin : g_cmp
    assign hit[n] = (PW'(n) * PW'(tck_ps)) >= PW'(twr_ps);
  end

  always_comb begin
    cyc = '0;
    for (int n = WR_MAX; n >= 1; n--) begin
      if (hit[n]) cyc = CW'(n);
    end
  end

  assign wr_ok   = (int'(cyc) >= WR_MIN) && (int'(cyc) <= WR_MAX_OK);
  assign wr_code = 3'(cyc - 1'b1);

  // R7: an accepted count is the rounded-up quotient
  assert_wr_round_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> ((PW'(cyc) * PW'(tck_ps)) >= PW'(twr_ps)) &&
              ((PW'(cyc - 1'b1) * PW'(tck_ps)) < PW'(twr_ps)));

endmodule

// File: rtl/mrs_word_pack.sv
module mrs_word_pack
  import ddr2_mrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mr_fields_t        mr_f,
  input  emr_fields_t       emr_f,
  input  logic [2:0]        wr_code,
  input  logic              wr_ok,
  output logic [ADDR_W-1:0] mr_word,
  output logic [ADDR_W-1:0] emr_word,
  output logic              mr_ok
);

  logic bl_ok;
  logic cl_ok;

  assign bl_ok = (mr_f.bl == BL_CODE_4) || (mr_f.bl == BL_CODE_8);
  assign cl_ok = (int'(mr_f.cl) >= CL_MIN) && (int'(mr_f.cl) <= CL_MAX);
  assign mr_ok = bl_ok && cl_ok && wr_ok;

  always_comb begin
    mr_word        = '0;
    mr_word[2:0]   = mr_f.bl;
    mr_word[3]     = mr_f.bt;
    mr_word[6:4]   = mr_f.cl;
    mr_word[7]     = 1'b0;
    mr_word[8]     = mr_f.dll_rst;
    mr_word[11:9]  = wr_code;
    mr_word[12]    = mr_f.pd_slow;
    mr_word[13]    = 1'b0;
  end

  always_comb begin
    emr_word       = '0;
    emr_word[0]    = emr_f.dll_off;
    emr_word[1]    = emr_f.drv_half;
    emr_word[2]    = emr_f.odt[0];
    emr_word[5:3]  = emr_f.al;
    emr_word[6]    = emr_f.odt[1];
    emr_word[9:7]  = emr_f.drv_cal;
    emr_word[10]   = emr_f.strobe_cmp_off;
    emr_word[11]   = emr_f.rdstrobe_on;
  end

  // R5: an accepted base word always carries a 4 or 8 burst code
  assert_bl_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mr_ok |-> (mr_word[2:1] == 2'b01));

  // R5: an accepted base word carries a latency of 3..6
  assert_cl_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mr_ok |-> (mr_word[6:4] >= 3'd3 && mr_word[6:4] <= 3'd6));

endmodule

// File: rtl/mrs_gap_timer.sv
module mrs_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic win_idle,
  output logic expire
);

  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (fire) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign win_idle = (cnt == '0);

  generate
    if (GAP == 1) begin : g_single
      assign expire = fire;
    end else begin : g_multi
      assign expire = (cnt == CNT_W'(1));
    end
  endgenerate

  // R4: a command is never launched inside an open window
  assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cnt == '0));

endmodule

// File: rtl/ddr2_mrs_seq.sv
module ddr2_mrs_seq
  import ddr2_mrs_pkg::*;
#(
  parameter int MRS_GAP = 4,
  parameter int PS_W    = 16,
  parameter int WR_MAX  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            banks_idle,
  input  logic            cke_on,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_sel,
  input  logic [2:0]      cfg_bl,
  input  logic            cfg_bt,
  input  logic [2:0]      cfg_cl,
  input  logic            cfg_dll_rst,
  input  logic            cfg_pd_slow,
  input  logic [PS_W-1:0] cfg_twr_ps,
  input  logic [PS_W-1:0] cfg_tck_ps,
  input  logic            cfg_dll_off,
  input  logic            cfg_drv_half,
  input  logic [1:0]      cfg_odt,
  input  logic [2:0]      cfg_al,
  input  logic [2:0]      cfg_drv_cal,
  input  logic            cfg_strobe_cmp_off,
  input  logic            cfg_rdstrobe_on,
  output logic            cmd_csel_n,
  output logic            cmd_rowstb_n,
  output logic            cmd_colstb_n,
  output logic            cmd_wen_n,
  output logic [1:0]      cmd_bank,
  output logic [13:0]     cmd_addr,
  output logic            done,
  output logic            err,
  output logic            configured
);

  mr_fields_t        mr_f;
  emr_fields_t       emr_f;
  logic [2:0]        wr_code;
  logic              wr_ok;
  logic [ADDR_W-1:0] mr_word;
  logic [ADDR_W-1:0] emr_word;
  logic              mr_ok;
  logic              win_idle;
  logic              expire;
  logic              accept;
  logic              sel_ok;
  logic              fire;

  logic              csel_q;
  logic              cmd_q;
  logic [1:0]        bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;
  logic              done_q;
  logic              mr_seen;
  logic              emr_seen;

  assign mr_f  = '{bl: cfg_bl, bt: cfg_bt, cl: cfg_cl,
                   dll_rst: cfg_dll_rst, pd_slow: cfg_pd_slow};
  assign emr_f = '{dll_off: cfg_dll_off, drv_half: cfg_drv_half,
                   odt: cfg_odt, al: cfg_al, drv_cal: cfg_drv_cal,
                   strobe_cmp_off: cfg_strobe_cmp_off,
                   rdstrobe_on: cfg_rdstrobe_on};

  mrs_wr_calc #(.PS_W(PS_W), .WR_MAX(WR_MAX)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .twr_ps  (cfg_twr_ps),
    .tck_ps  (cfg_tck_ps),
    .wr_code (wr_code),
    .wr_ok   (wr_ok)
  );

  mrs_word_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_f     (mr_f),
    .emr_f    (emr_f),
    .wr_code  (wr_code),
    .wr_ok    (wr_ok),
    .mr_word  (mr_word),
    .emr_word (emr_word),
    .mr_ok    (mr_ok)
  );

  mrs_gap_timer #(.GAP(MRS_GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .win_idle (win_idle),
    .expire   (expire)
  );

  // Handshake: held off while preconditions fail or a window is open
  assign req_ready = banks_idle && cke_on && win_idle;
  assign accept    = req_valid && req_ready;
  assign sel_ok    = (reg_sel_e'(req_sel) == SEL_EMR1) || mr_ok;
  assign fire      = accept && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q   <= 1'b1;
      cmd_q    <= 1'b0;
      bank_q   <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      mr_seen  <= 1'b0;
      emr_seen <= 1'b0;
    end else begin
      csel_q <= 1'b0;
      cmd_q  <= fire;
      bank_q <= fire ? {1'b0, req_sel} : 2'b00;
      if (fire) begin
        addr_q <= (reg_sel_e'(req_sel) == SEL_EMR1) ? emr_word : mr_word;
      end else begin
        addr_q <= '0;
      end
      err_q  <= accept && !sel_ok;
      done_q <= expire;
      if (fire && reg_sel_e'(req_sel) == SEL_MR)   mr_seen  <= 1'b1;
      if (fire && reg_sel_e'(req_sel) == SEL_EMR1) emr_seen <= 1'b1;
    end
  end

  assign cmd_csel_n   = csel_q;
  assign cmd_rowstb_n = !cmd_q;
  assign cmd_colstb_n = !cmd_q;
  assign cmd_wen_n    = !cmd_q;
  assign cmd_bank     = bank_q;
  assign cmd_addr     = addr_q;
  assign done         = done_q;
  assign err          = err_q;
  assign configured   = mr_seen && emr_seen && win_idle;

  // R1: row strobe high means a full no-operation code on the bus
  assert_nop_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rowstb_n |-> (cmd_colstb_n && cmd_wen_n && cmd_bank == 2'b00 &&
                      cmd_addr == '0));

  // R2: good handshake gives a command next cycle with the selected bank
  assert_cmd_after_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel_ok) |=> (!cmd_rowstb_n && !cmd_colstb_n && !cmd_wen_n &&
                            cmd_bank == {1'b0, $past(req_sel)}));

  // R3: ready only with all banks precharged and clock enable high
  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (banks_idle && cke_on));

  // R6: the top address bit is never set in a command
  assert_a13_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rowstb_n |-> (cmd_addr[13] == 1'b0));

  // R8: an error cycle carries no command
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cmd_rowstb_n);

  // R10: configured implies a free bus for the next request
  assert_cfg_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && banks_idle && cke_on) |-> req_ready);

endmodule

// File: tb/ddr2_mrs_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_mrs_seq_tb_top;

  localparam int GAP  = 4;
  localparam int PS_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle, cke_on, req_valid, req_ready, req_sel;
  logic [2:0] cfg_bl, cfg_cl, cfg_al, cfg_drv_cal;
  logic cfg_bt, cfg_dll_rst, cfg_pd_slow, cfg_dll_off, cfg_drv_half;
  logic [1:0] cfg_odt;
  logic cfg_strobe_cmp_off, cfg_rdstrobe_on;
  logic [PS_W-1:0] cfg_twr_ps, cfg_tck_ps;
  logic cmd_csel_n, cmd_rowstb_n, cmd_colstb_n, cmd_wen_n;
  logic [1:0] cmd_bank;
  logic [13:0] cmd_addr;
  logic done, err, configured;

  always #2.5 clk = ~clk;

  ddr2_mrs_seq #(.MRS_GAP(GAP), .PS_W(PS_W), .WR_MAX(7)) dut_i (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  int m_busy, m_cs, m_cmd, m_ba, m_addr, m_err, m_done, m_mr, m_emr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cs = 1; m_cmd = 0; m_ba = 0; m_addr = 0;
      m_err = 0; m_done = 0; m_mr = 0; m_emr = 0;
    end else begin
      int wrc, word, nd;
      bit acc, good, mr_good;
      acc = req_valid && banks_idle && cke_on && (m_busy == 0);
      wrc = (int'(cfg_twr_ps) + int'(cfg_tck_ps) - 1) / int'(cfg_tck_ps);
      mr_good = (cfg_bl == 3'd2 || cfg_bl == 3'd3) && cfg_cl >= 3 && cfg_cl <= 6
                && wrc >= 2 && wrc <= 6;
      good = acc && (req_sel || mr_good);
      if (req_sel)
        word = int'(cfg_dll_off) + (int'(cfg_drv_half) << 1) + (int'(cfg_odt[0]) << 2)
             + (int'(cfg_al) << 3) + (int'(cfg_odt[1]) << 6) + (int'(cfg_drv_cal) << 7)
             + (int'(cfg_strobe_cmp_off) << 10) + (int'(cfg_rdstrobe_on) << 11);
      else
        word = int'(cfg_bl) + (int'(cfg_bt) << 3) + (int'(cfg_cl) << 4)
             + (int'(cfg_dll_rst) << 8) + (((wrc - 1) & 7) << 9) + (int'(cfg_pd_slow) << 12);
      nd = (m_busy == 1 || (good && GAP == 1)) ? 1 : 0;
      m_cs   = 0;
      m_err  = (acc && !good) ? 1 : 0;
      m_cmd  = good ? 1 : 0;
      m_ba   = good ? (req_sel ? 1 : 0) : 0;
      m_addr = good ? word : 0;
      if (good && !req_sel) m_mr = 1;
      if (good && req_sel)  m_emr = 1;
      m_busy = good ? GAP - 1 : (m_busy > 0 ? m_busy - 1 : 0);
      m_done = nd;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0, last_cmd = -1, min_gap = 1000, cmd_cnt = 0, done_cnt = 0, err_cnt = 0;
  int last_addr = 0, last_bank = 0;

  task automatic tick();
    int eready, ecfg;
    @(negedge clk);
    eready = (banks_idle && cke_on && m_busy == 0) ? 1 : 0;
    ecfg   = (m_mr && m_emr && m_busy == 0) ? 1 : 0;
    check(cmd_csel_n == m_cs[0], "R1 chip select", cmd_csel_n, m_cs);
    check(cmd_rowstb_n == !m_cmd[0] && cmd_colstb_n == !m_cmd[0] && cmd_wen_n == !m_cmd[0],
          "R2 strobes", cmd_rowstb_n, !m_cmd[0]);
    check(int'(cmd_bank) == m_ba, "R2 bank", cmd_bank, m_ba);
    check(int'(cmd_addr) == m_addr, m_ba == 1 ? "R6 word" : "R5 word", cmd_addr, m_addr);
    check(int'(req_ready) == eready, "R3 ready", req_ready, eready);
    check(int'(err) == m_err, "R8 err", err, m_err);
    check(int'(done) == m_done, "R9 done", done, m_done);
    check(int'(configured) == ecfg, "R10 configured", configured, ecfg);
    if (!cmd_rowstb_n) begin
      if (last_cmd >= 0 && cyc - last_cmd < min_gap) min_gap = cyc - last_cmd;
      last_cmd = cyc; cmd_cnt++; last_addr = int'(cmd_addr); last_bank = int'(cmd_bank);
    end
    if (done) done_cnt++;
    if (err) err_cnt++;
    cyc++;
  endtask

  task automatic send(input bit sel);
    bit hs;
    req_sel = sel; req_valid = 1'b1;
    do begin
      #1 hs = req_ready;
      tick();
    end while (!hs);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0, e0;
    banks_idle = 1; cke_on = 1; req_valid = 0; req_sel = 0;
    cfg_bl = 3'd3; cfg_bt = 0; cfg_cl = 3'd5; cfg_dll_rst = 0; cfg_pd_slow = 0;
    cfg_twr_ps = 16'd15000; cfg_tck_ps = 16'd3750;
    cfg_dll_off = 0; cfg_drv_half = 0; cfg_odt = 2'b01; cfg_al = 3'd0;
    cfg_drv_cal = 3'd0; cfg_strobe_cmp_off = 0; cfg_rdstrobe_on = 0;
    idle(3);
    // R11: reset state
    check(!done && !err && !configured && cmd_rowstb_n && cmd_csel_n,
          "R11 reset outputs", {done, err, configured}, 0);
    rst_n = 1'b1;
    idle(2);
    // R1: idle bus carries no-operation code
    check(!cmd_csel_n && cmd_rowstb_n && cmd_colstb_n && cmd_wen_n, "R1 idle nop",
          {cmd_csel_n, cmd_rowstb_n}, 1);

    // R3: held off while banks open, then while clock enable low
    c0 = cmd_cnt;
    banks_idle = 0; req_sel = 1; req_valid = 1;
    idle(6);
    banks_idle = 1; cke_on = 0;
    idle(3);
    check(cmd_cnt == c0, "R3 no command without preconditions", cmd_cnt, c0);
    cke_on = 1;
    send(1);
    idle(GAP + 1);
    check(configured == 0, "R10 only extended written", configured, 0);
    send(0);
    idle(GAP + 1);
    check(configured == 1, "R10 both written", configured, 1);
    check(((last_addr >> 9) & 7) == 3, "R7 15000/3750", (last_addr >> 9) & 7, 3);

    // R7: rounding at and just above an exact multiple
    cfg_twr_ps = 16'd15000; cfg_tck_ps = 16'd7500;
    send(0); idle(GAP);
    check(((last_addr >> 9) & 7) == 1, "R7 exact multiple", (last_addr >> 9) & 7, 1);
    cfg_twr_ps = 16'd15001;
    send(0); idle(GAP);
    check(((last_addr >> 9) & 7) == 2, "R7 round up", (last_addr >> 9) & 7, 2);

    // R4: back-to-back requests
    min_gap = 1000;
    send(1); send(0); send(1); send(0);
    idle(GAP);
    check(min_gap == GAP, "R4 spacing", min_gap, GAP);
    check(last_bank == 0, "R2 base bank", last_bank, 0);

    // R8: reserved codes rejected
    c0 = cmd_cnt; e0 = err_cnt;
    cfg_bl = 3'd1; send(0); idle(2); cfg_bl = 3'd3;
    cfg_cl = 3'd7; send(0); idle(2);
    cfg_cl = 3'd2; send(0); idle(2); cfg_cl = 3'd4;
    cfg_twr_ps = 16'd35000; cfg_tck_ps = 16'd5000; send(0); idle(2);
    cfg_twr_ps = 16'd3000; send(0); idle(2);
    check(cmd_cnt == c0, "R8 no command on reserved", cmd_cnt, c0);
    check(err_cnt == e0 + 5, "R8 error pulses", err_cnt, e0 + 5);
    // extended request with bad base fields still issues
    cfg_bl = 3'd0;
    e0 = err_cnt;
    cfg_dll_off = 1; cfg_odt = 2'b10; cfg_al = 3'd3; cfg_drv_cal = 3'd7;
    cfg_strobe_cmp_off = 1; cfg_rdstrobe_on = 0;
    send(1); idle(GAP);
    check(cmd_cnt == c0 + 1 && err_cnt == e0, "R8 extended not rejected", cmd_cnt, c0 + 1);
    check(last_addr == 2009, "R6 extended word", last_addr, 2009);
    check(last_bank == 1, "R2 extended bank", last_bank, 1);

    // R5: base word layout
    cfg_bl = 3'd2; cfg_bt = 1; cfg_cl = 3'd3; cfg_dll_rst = 1; cfg_pd_slow = 1;
    cfg_twr_ps = 16'd10000; cfg_tck_ps = 16'd2500;
    send(0); idle(GAP + 2);
    check(last_addr == 5946, "R5 base word", last_addr, 5946);

    // R9: one done pulse per command
    check(done_cnt == cmd_cnt, "R9 done count", done_cnt, cmd_cnt);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule